// File: doc/BRIEF.md
# Dual-compare PWM counter timer

This block is an up-counter with two compare registers, called A and B, behind a small word-wide register interface. While the run flag is set, the counter advances by one on every clock in which the count-enable input `cntPulse` is high. When the counter equals compare B on such an advance, it returns to zero instead of incrementing, and that return marks the end of a period. When the counter equals compare A on an advance, the PWM output goes low. Every return to zero drives the output high again. The duty cycle is therefore set by A and the period by B.

Software controls the block through a control register. That register holds the run flag, a write-only counter-clear strobe, a repeat/one-shot mode bit and a compare-buffer enable. With buffering off, compare writes take effect at once. With buffering on, compare writes go to shadow copies, and those copies move into the active compares only at the end of a period, so a running waveform never sees a half-updated pair. In one-shot mode the block stops itself after a single period.

Top module: `pwm_cmp_timer`

## Requirements
- R1: The register map is: control at address 0 (bit 0 run, bit 1 counter clear, bit 2 one-shot mode, bit 3 buffer enable, all other bits read 0), compare A at address 1, compare B at address 2 and the counter at address 3 (read only). After reset, every register reads 0 and `pwmOut` is low.
- R2: Writing 1 to control bit 0 starts counting. While running, each cycle with `cntPulse` high adds one to the counter. A cycle with `cntPulse` low leaves the counter unchanged. The counter can be read at address 3 at any time.
- R3: Writing 0 to control bit 0 stops the counter, which then keeps its value whatever `cntPulse` does. A later start resumes counting from that value.
- R4: On an advance in which the counter equals active compare B, the counter becomes 0 on the next cycle instead of incrementing. This is the end of a period.
- R5: In repeat mode (bit 2 = 0), the run bit stays 1 across the end of a period, and counting continues.
- R6: In one-shot mode (bit 2 = 1), the end of a period clears the run bit by itself, so the control register reads bit 0 as 0 from then on.
- R7: A control write with bit 1 = 1 sets the counter to 0. Such a write with bit 1 = 0 leaves the counter alone. Bit 1 always reads 0. If the clear falls on a cycle that would end a period, the clear takes precedence: there is no one-shot stop and no shadow load.
- R8: With buffering off (bit 3 = 0), a write to address 1 or 2 updates the active compare at once, and the new value reads back on the next cycle.
- R9: With buffering on, compare writes update only the shadow copies. Reads return the active values. Both shadows are copied into the active compares at the end of a period. A write made while buffering is off also refreshes the shadow.
- R10: `pwmOut` goes high on the cycle after any return to zero (end of a period or software clear). It goes low on the cycle after an advance in which the counter equals active compare A, unless that same advance ends the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe for the current cycle |
| addr | input | AW (2) | Register address for both reads and writes |
| wrData | input | DW (16) | Write data |
| rdData | output | DW (16) | Combinational read data for `addr` |
| cntPulse | input | 1 | Count enable; one advance per high cycle while running |
| pwmOut | output | 1 | PWM waveform output |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that a control write is the only thing that sets the run flag, so each one-shot and repeat property excludes cycles that carry a control write. They also assume that compare B is never moved below the live count with buffering off, because the counter would then wrap through the full range before it matches again. The stimulus respects this: it changes compare B directly only while the counter is cleared or stopped near zero. All random compare traffic happens with buffering on, where new values take effect only after the counter has returned to zero.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
package pwm_tmr_pkg;

  // register addresses
  localparam int REG_CTRL  = 0;
  localparam int REG_CMPA  = 1;
  localparam int REG_CMPB  = 2;
  localparam int REG_COUNT = 3;

  // control register bit positions
  localparam int BIT_RUN  = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_MODE = 2;
  localparam int BIT_BUF  = 3;
  localparam int CTRL_W   = 4;

  // compare channels: index 0 = duty (A), index 1 = period (B)
  localparam int NUM_CMP = 2;
  localparam int IDX_A   = 0;
  localparam int IDX_B   = 1;

  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic tick;     // counter advance this cycle
    logic softClr;  // software counter clear
    logic wrCmpA;   // write to compare A address
    logic wrCmpB;   // write to compare B address
    logic bufEn;    // compare buffering active (pre-write value)
  } tmr_stb_t;

endpackage

// File: rtl/pwm_tmr_ctrl.sv
`timescale 1ns/1ps
module pwm_tmr_ctrl
  import pwm_tmr_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [AW-1:0]     addr,
  input  logic [CTRL_W-1:0] ctrlBits,
  input  logic              cntPulse,
  input  logic              periodEnd,
  output tmr_stb_t          stb,
  output logic              runBit,
  output logic              oneShot,
  output logic              bufEn
);

  logic ctrlWr;
  logic cmpAWr;
  logic cmpBWr;

  assign ctrlWr = wrEn && (addr == AW'(REG_CTRL));
  assign cmpAWr = wrEn && (addr == AW'(REG_CMPA));
  assign cmpBWr = wrEn && (addr == AW'(REG_CMPB));

  // run / mode / buffer flags; a software write beats the one-shot auto stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runBit  <= 1'b0;
      oneShot <= 1'b0;
      bufEn   <= 1'b0;
    end else if (ctrlWr) begin
      runBit  <= ctrlBits[BIT_RUN];
      oneShot <= ctrlBits[BIT_MODE];
      bufEn   <= ctrlBits[BIT_BUF];
    end else if (periodEnd && oneShot) begin
      runBit  <= 1'b0;
    end
  end

  always_comb begin
    stb.tick    = runBit && cntPulse;
    stb.softClr = ctrlWr && ctrlBits[BIT_CLR];
    stb.wrCmpA  = cmpAWr;
    stb.wrCmpB  = cmpBWr;
    stb.bufEn   = bufEn;
  end

endmodule

// File: rtl/pwm_tmr_dp.sv
`timescale 1ns/1ps
module pwm_tmr_dp
  import pwm_tmr_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_stb_t      stb,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] addr,
  input  logic          runBit,
  input  logic          oneShot,
  input  logic          bufEn,
  output logic [DW-1:0] rdData,
  output logic          pwmOut,
  output logic          periodEnd,
  output logic [DW-1:0] cntVal,
  output logic [DW-1:0] actA,
  output logic [DW-1:0] actB
);

  logic [NUM_CMP-1:0][DW-1:0] actVec;
  logic [NUM_CMP-1:0]         wrSel;
  logic [DW-1:0]              cntQ;
  logic                       hitA;
  logic                       hitB;
  logic                       pwmQ;

  assign wrSel[IDX_A] = stb.wrCmpA;
  assign wrSel[IDX_B] = stb.wrCmpB;

  assign hitA      = stb.tick && (cntQ == actVec[IDX_A]);
  assign hitB      = stb.tick && (cntQ == actVec[IDX_B]);
  assign periodEnd = hitB && !stb.softClr;

  // one active/shadow pair per compare channel
  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      logic [DW-1:0] activeQ;
      logic [DW-1:0] shadowQ;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          activeQ <= '0;
          shadowQ <= '0;
        end else begin
          if (wrSel[g]) begin
            shadowQ <= wrData;
          end
          if (stb.bufEn) begin
            if (periodEnd) begin
              activeQ <= shadowQ;
            end
          end else if (wrSel[g]) begin
            activeQ <= wrData;
          end
        end
      end

      assign actVec[g] = activeQ;
    end
  endgenerate

  // counter: software clear, then period wrap, then advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (stb.softClr || hitB) begin
      cntQ <= '0;
    end else if (stb.tick) begin
      cntQ <= cntQ + DW'(1);
    end
  end

  // waveform: high on return to zero, low on duty match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwmQ <= 1'b0;
    end else if (stb.softClr || periodEnd) begin
      pwmQ <= 1'b1;
    end else if (hitA) begin
      pwmQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      AW'(REG_CTRL): begin
        rdData[BIT_RUN]  = runBit;
        rdData[BIT_MODE] = oneShot;
        rdData[BIT_BUF]  = bufEn;
      end
      AW'(REG_CMPA): rdData = actVec[IDX_A];
      AW'(REG_CMPB): rdData = actVec[IDX_B];
      default:       rdData = cntQ;
    endcase
  end

  assign pwmOut = pwmQ;
  assign cntVal = cntQ;
  assign actA   = actVec[IDX_A];
  assign actB   = actVec[IDX_B];

endmodule

// File: rtl/pwm_cmp_timer.sv
`timescale 1ns/1ps
module pwm_cmp_timer
  import pwm_tmr_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic          cntPulse,
  output logic          pwmOut
);

  tmr_stb_t      stb;
  logic          runBit;
  logic          oneShot;
  logic          bufEn;
  logic          periodEnd;
  logic [DW-1:0] cntVal;
  logic [DW-1:0] actA;
  logic [DW-1:0] actB;

  pwm_tmr_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .addr      (addr),
    .ctrlBits  (wrData[CTRL_W-1:0]),
    .cntPulse  (cntPulse),
    .periodEnd (periodEnd),
    .stb       (stb),
    .runBit    (runBit),
    .oneShot   (oneShot),
    .bufEn     (bufEn)
  );

  pwm_tmr_dp #(.DW(DW), .AW(AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .wrData    (wrData),
    .addr      (addr),
    .runBit    (runBit),
    .oneShot   (oneShot),
    .bufEn     (bufEn),
    .rdData    (rdData),
    .pwmOut    (pwmOut),
    .periodEnd (periodEnd),
    .cntVal    (cntVal),
    .actA      (actA),
    .actB      (actB)
  );

endmodule

// File: rtl/pwm_cmp_timer_chk.sv
`timescale 1ns/1ps
module pwm_cmp_timer_chk #(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wrEn,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] rdData,
  input logic          cntPulse,
  input logic          pwmOut,
  input logic          runBit,
  input logic          oneShot,
  input logic          bufEn,
  input logic          periodEnd,
  input logic [DW-1:0] cntVal,
  input logic [DW-1:0] actA,
  input logic [DW-1:0] actB
);

  logic ctrlWr;
  logic clrWr;
  assign ctrlWr = wrEn && (addr == AW'(0));
  assign clrWr  = ctrlWr && wrData[1];

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (runBit && cntPulse && (cntVal != actB) && !clrWr) |=> cntVal == DW'($past(cntVal) + DW'(1)));

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!runBit && !clrWr) |=> $stable(cntVal));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd |=> cntVal == '0);

  p_repeat_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (periodEnd && !oneShot && !ctrlWr) |=> runBit);

  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (periodEnd && oneShot && !ctrlWr) |=> !runBit);

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clrWr |=> cntVal == '0);

  p_clear_reads0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(0)) |-> !rdData[1]);

  p_direct_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == AW'(1) && !bufEn) |=> actA == $past(wrData));

  p_direct_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == AW'(2) && !bufEn) |=> actB == $past(wrData));

  p_buffered_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bufEn && !periodEnd) |=> ($stable(actA) && $stable(actB)));

  p_pwm_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (periodEnd || clrWr) |=> pwmOut);

  p_pwm_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (runBit && cntPulse && cntVal == actA && cntVal != actB && !clrWr) |=> !pwmOut);

endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .cntPulse  (cntPulse),
  .pwmOut    (pwmOut),
  .runBit    (runBit),
  .oneShot   (oneShot),
  .bufEn     (bufEn),
  .periodEnd (periodEnd),
  .cntVal    (cntVal),
  .actA      (actA),
  .actB      (actB)
);

// File: tb/tb_pwm_cmp_timer.sv
`timescale 1ns/1ps
module tb_pwm_cmp_timer;
  localparam int DW = 16;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic          cntPulse = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          pwmOut;

  always #10 clk = ~clk;

  pwm_cmp_timer #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cntPulse(cntPulse), .pwmOut(pwmOut)
  );

  int    checks = 0;
  int    fails = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference model
  int mCnt, mRun, mOne, mBuf, mPwm;
  int mAct[2];
  int mShd[2];
  bit ctrlW, clr, tick, endP, aHit;
  int oldBuf, oldS0, oldS1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCnt = 0; mRun = 0; mOne = 0; mBuf = 0; mPwm = 0;
      mAct[0] = 0; mAct[1] = 0; mShd[0] = 0; mShd[1] = 0;
    end else begin
      ctrlW  = wrEn && (addr == 0);
      clr    = ctrlW && wrData[1];
      tick   = (mRun == 1) && cntPulse;
      endP   = tick && (mCnt == mAct[1]) && !clr;
      aHit   = tick && (mCnt == mAct[0]);
      oldBuf = mBuf; oldS0 = mShd[0]; oldS1 = mShd[1];
      if (clr) mCnt = 0;
      else if (tick) mCnt = (mCnt == mAct[1]) ? 0 : (mCnt + 1) % 65536;
      if (clr || endP) mPwm = 1;
      else if (aHit) mPwm = 0;
      if (ctrlW) begin
        mRun = int'(wrData[0]); mOne = int'(wrData[2]); mBuf = int'(wrData[3]);
      end else if (endP && mOne == 1) begin
        mRun = 0;
      end
      if (oldBuf == 1 && endP) begin
        mAct[0] = oldS0; mAct[1] = oldS1;
      end
      if (wrEn && addr == 1) begin
        mShd[0] = int'(wrData);
        if (oldBuf == 0) mAct[0] = int'(wrData);
      end
      if (wrEn && addr == 2) begin
        mShd[1] = int'(wrData);
        if (oldBuf == 0) mAct[1] = int'(wrData);
      end
    end
  end

  function automatic logic [DW-1:0] expRd(input logic [AW-1:0] a);
    case (a)
      2'd0:    return DW'(mBuf * 8 + mOne * 4 + mRun);
      2'd1:    return DW'(mAct[0]);
      2'd2:    return DW'(mAct[1]);
      default: return DW'(mCnt);
    endcase
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against model every clock, three quarters into the cycle
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(tag, rdData, expRd(addr));
      chk(tag, DW'(pwmOut), DW'(mPwm));
    end
  end

  task automatic stepIdle(input bit p, input logic [AW-1:0] a);
    @(negedge clk);
    wrEn = 1'b0; addr = a; cntPulse = p;
  endtask

  task automatic stepWr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit p);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; cntPulse = p;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    tag = "R1";
    stepIdle(0, 0); #5 chk("R1", rdData, 16'h0000);
    stepIdle(0, 3); #5 chk("R1", rdData, 16'h0000);
    chk("R1", DW'(pwmOut), 16'h0000);

    // R8: direct compare writes
    tag = "R8";
    stepWr(1, 16'd3, 0);
    stepWr(2, 16'd7, 0);
    stepIdle(0, 1); #5 chk("R8", rdData, 16'd3);
    stepIdle(0, 2); #5 chk("R8", rdData, 16'd7);

    // R2: start and count on pulses
    tag = "R2";
    stepWr(0, 16'h1, 0);
    for (int i = 0; i < 5; i++) stepIdle(1, 3);
    for (int i = 0; i < 6; i++) stepIdle(i[0], 3);

    // R4 / R10: free running periods
    tag = "R4";
    for (int i = 0; i < 20; i++) stepIdle(1, 3);
    tag = "R10";
    for (int i = 0; i < 12; i++) stepIdle(1, 3);

    // R3: stop holds, restart resumes
    tag = "R3";
    stepWr(0, 16'h0, 1);
    for (int i = 0; i < 5; i++) stepIdle(1, 3);
    stepWr(0, 16'h1, 0);
    for (int i = 0; i < 4; i++) stepIdle(1, 3);

    // R5: repeat mode keeps running
    tag = "R5";
    for (int i = 0; i < 20; i++) stepIdle(1, 0);

    // R6: one-shot stops after one period
    tag = "R6";
    stepWr(0, 16'h2, 0);
    stepWr(0, 16'h5, 0);
    for (int i = 0; i < 12; i++) stepIdle(1, 3);
    stepIdle(0, 0); #5 chk("R6", rdData, 16'h0004);

    // R7: software clear
    tag = "R7";
    stepWr(0, 16'h1, 0);
    for (int i = 0; i < 3; i++) stepIdle(1, 3);
    stepWr(0, 16'h3, 1);
    stepIdle(1, 0); #5 chk("R7", rdData, 16'h0001);
    for (int i = 0; i < 3; i++) stepIdle(1, 3);
    stepWr(0, 16'h1, 1);
    stepIdle(1, 3);
    // clear on the same cycle as a compare-B match, buffering on
    stepWr(0, 16'h2, 0);
    stepWr(0, 16'h8, 0);
    stepWr(1, 16'd9, 0);
    stepWr(0, 16'h9, 0);
    for (int i = 0; i < 7; i++) stepIdle(1, 1);
    stepWr(0, 16'hB, 1);
    stepIdle(0, 1); #5 chk("R7", rdData, 16'd3);

    // R9: buffered compare updates
    tag = "R9";
    for (int i = 0; i < 10; i++) stepIdle(1, 1);
    stepWr(2, 16'd12, 1);
    stepWr(1, 16'd5, 1);
    for (int i = 0; i < 30; i++) stepIdle(1, AW'(1 + (i % 2)));

    // R10: pseudo-random pulses and buffered compare traffic
    tag = "R10";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0)      stepWr(1, DW'(lfsr[8:4]), lfsr[9]);
      else if (lfsr[3:0] == 4'd1) stepWr(2, DW'({lfsr[8:5], 1'b1}), lfsr[9]);
      else                        stepIdle(lfsr[9] | lfsr[10], lfsr[12:11]);
    end
    stepIdle(0, 0);
    stepIdle(0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule